// File: doc/BRIEF.md
# Four-Phase Clock Generator with Programmable Bus Divider

This block runs on an oscillator clock at four times the core rate. A small state machine turns that clock into four non-overlapping phase strobes for the core logic. Exactly one strobe is high in each oscillator cycle, and the strobes step through the phases in fixed order. A four-cycle group of oscillator cycles makes one core cycle. A one-cycle core tick marks the last oscillator cycle of each core cycle.

A second stage counts core cycles to produce an external bus clock enable. The bus clock runs at one half, one third or one quarter of the core rate. The enable stays high for one whole core cycle at the start of each bus period. The ratio input is sampled only at a bus-period boundary, so changing it never cuts a bus period short. Every output is a registered-state enable timed by the oscillator clock. The block has no data stream, so it has no valid/ready handshake. The ratio select is a plain control pin.

Top module: `quad_phase_clkgen`

## Requirements
- R1: `phase_o` is one-hot in every oscillator cycle. Out of reset, bit 0 (phase 1) is high. Each following cycle moves the high bit up by one, and bit 3 (phase 4) wraps back to bit 0.
- R2: While `rst` is high at a rising edge, the phase state returns to phase 1 and the bus counter is cleared. After that edge `phase_o` = 4'b0001, `core_tick_o` = 0 and `bus_en_o` = 1.
- R3: `core_tick_o` is high only in the oscillator cycle in which phase 4 is active. It is therefore high once in every four oscillator cycles.
- R4: `ratio_sel` encoding: 2'b00 selects a divide-by-2 bus clock and 2'b10 selects divide-by-4. Both 2'b01 and 2'b11 select the fixed divide-by-3 setting.
- R5: `bus_en_o` is high for exactly one core cycle (four oscillator cycles) out of every N core cycles, where N is the active ratio.
- R6: The divider loads `ratio_sel` only at an edge where `core_tick_o` is high and the last core cycle of a bus period is ending. While `rst` is high it loads `ratio_sel` at every edge. A change at any other time does not alter the current bus period.
- R7: `bus_en_o` rises only in an oscillator cycle where phase 1 is active. It falls only right after a cycle with `core_tick_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock, four times the core rate |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Bus clock ratio select (see R4) |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = phase 1 |
| core_tick_o | output | 1 | High in the last oscillator cycle of each core cycle |
| bus_en_o | output | 1 | Bus clock enable, high for one core cycle per bus period |

## Verification
Suppose the phase state is corrupted, for example a skipped or repeated phase. Then `phase_o` loses its one-hot rotation at once, within a single oscillator cycle, and `core_tick_o` moves off the phase-4 slot. A wrong bus counter or a wrongly latched ratio shows up only at the next bus boundary. There `bus_en_o` rises a whole core cycle early or late, which takes up to sixteen oscillator cycles with the slowest ratio. For this reason ratio changes are driven both mid-period and right at a boundary, so that a change applied at the wrong moment shows up as a misplaced rise within one bus period.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NUM_PHASES = 4;
  localparam int SEL_W      = 2;
  localparam int DIV_W      = 3;

  typedef logic [SEL_W-1:0] ratio_sel_t;
  typedef logic [DIV_W-1:0] div_t;

  function automatic div_t ratio_decode(input ratio_sel_t sel);
    case (sel)
      2'b00:   ratio_decode = div_t'(2);
      2'b10:   ratio_decode = div_t'(4);
      default: ratio_decode = div_t'(3);
    endcase
  endfunction
endpackage

// File: rtl/clkgen_phase_ring.sv
module clkgen_phase_ring #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [NP-1:0] phase_o,
  output logic          last_o
);
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1;

  logic [IDX_W-1:0] idx_q;

  assign last_o = (idx_q == IDX_W'(NP-1));

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (last_o) idx_q <= '0;
    else             idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < NP; g++) begin : g_strobe
    assign phase_o[g] = (idx_q == IDX_W'(g));
  end
endmodule

// File: rtl/clkgen_bus_div.sv
module clkgen_bus_div
  import clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv_i,
  input  ratio_sel_t ratio_sel_i,
  output logic       bus_en_o
);
  div_t cnt_q;
  div_t ratio_q;
  logic wrap;

  assign wrap     = (cnt_q == ratio_q - 1'b1);
  assign bus_en_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= ratio_decode(ratio_sel_i);
    end else if (adv_i) begin
      if (wrap) begin
        cnt_q   <= '0;
        ratio_q <= ratio_decode(ratio_sel_i);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/quad_phase_clkgen.sv
module quad_phase_clkgen
  import clkgen_pkg::*;
(
  input  logic                  clk_osc,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      ratio_sel,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  core_tick_o,
  output logic                  bus_en_o
);
  logic last_phase;

  clkgen_phase_ring #(.NP(NUM_PHASES)) u_ring (
    .clk     (clk_osc),
    .rst     (rst),
    .phase_o (phase_o),
    .last_o  (last_phase)
  );

  assign core_tick_o = last_phase;

  clkgen_bus_div u_div (
    .clk         (clk_osc),
    .rst         (rst),
    .adv_i       (last_phase),
    .ratio_sel_i (ratio_sel),
    .bus_en_o    (bus_en_o)
  );
endmodule

// File: rtl/quad_phase_clkgen_chk.sv
module quad_phase_clkgen_chk
  import clkgen_pkg::*;
(
  input logic                  clk_osc,
  input logic                  rst,
  input logic [NUM_PHASES-1:0] phase_o,
  input logic                  core_tick_o,
  input logic                  bus_en_o
);
  p_onehot_r1: assert property (@(posedge clk_osc) disable iff (rst)
    $countones(phase_o) == 1);

  p_rotate_r1: assert property (@(posedge clk_osc) disable iff (rst)
    1'b1 |=> phase_o == {$past(phase_o[NUM_PHASES-2:0]), $past(phase_o[NUM_PHASES-1])});

  p_tick_then_ph1_r3: assert property (@(posedge clk_osc) disable iff (rst)
    core_tick_o |=> phase_o[0]);

  p_tick_on_ph4_r3: assert property (@(posedge clk_osc) disable iff (rst)
    core_tick_o |-> phase_o[NUM_PHASES-1]);

  p_rise_ph1_r7: assert property (@(posedge clk_osc) disable iff (rst)
    $rose(bus_en_o) |-> phase_o[0]);

  p_hold_mid_r6: assert property (@(posedge clk_osc) disable iff (rst)
    !core_tick_o |=> $stable(bus_en_o));
endmodule

bind quad_phase_clkgen quad_phase_clkgen_chk u_chk (
  .clk_osc     (clk_osc),
  .rst         (rst),
  .phase_o     (phase_o),
  .core_tick_o (core_tick_o),
  .bus_en_o    (bus_en_o)
);

// File: tb/quad_phase_clkgen_tb.sv
module quad_phase_clkgen_tb;
  logic       clk_osc = 1'b0;
  logic       rst     = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic [3:0] phase_o;
  logic       core_tick_o;
  logic       bus_en_o;

  int checks = 0;
  int fails  = 0;
  string seg = "R2";

  int m_ph = 0;
  int m_bc = 0;
  int m_rat = 2;
  logic prev_en = 1'b1;

  always #4 clk_osc = ~clk_osc;

  quad_phase_clkgen u_dut (
    .clk_osc     (clk_osc),
    .rst         (rst),
    .ratio_sel   (ratio_sel),
    .phase_o     (phase_o),
    .core_tick_o (core_tick_o),
    .bus_en_o    (bus_en_o)
  );

  // R4 encoding
  function automatic int dec(input logic [1:0] s);
    if (s == 2'b00) return 2;
    if (s == 2'b10) return 4;
    return 3;
  endfunction

  task automatic step(input logic r, input logic [1:0] s);
    logic [3:0] exp_ph;
    rst = r;
    ratio_sel = s;
    @(posedge clk_osc);
    if (r) begin
      m_ph = 0; m_bc = 0; m_rat = dec(s);
    end else begin
      if (m_ph == 3) begin
        if (m_bc == m_rat - 1) begin m_bc = 0; m_rat = dec(s); end
        else m_bc = m_bc + 1;
      end
      m_ph = (m_ph + 1) % 4;
    end
    @(negedge clk_osc);
    exp_ph = 4'b0001 << m_ph;
    checks++;
    if (phase_o !== exp_ph) begin
      fails++;
      $display("FAIL R1 (%s) phase_o got %b exp %b", seg, phase_o, exp_ph);
    end
    checks++;
    if (core_tick_o !== (m_ph == 3)) begin
      fails++;
      $display("FAIL R3 (%s) core_tick_o got %b exp %b", seg, core_tick_o, (m_ph == 3));
    end
    checks++;
    if (bus_en_o !== (m_bc == 0)) begin
      fails++;
      $display("FAIL R5 (%s) bus_en_o got %b exp %b", seg, bus_en_o, (m_bc == 0));
    end
    checks++;
    if (bus_en_o === 1'b1 && prev_en === 1'b0 && phase_o !== 4'b0001) begin
      fails++;
      $display("FAIL R7 bus_en_o rose with phase_o got %b exp 0001", phase_o);
    end
    prev_en = bus_en_o;
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk_osc); wd++; end
    fails++;
    $display("FAIL watchdog expired got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    seg = "R2";
    for (int i = 0; i < 3; i++) step(1'b1, 2'b00);
    seg = "R4 div2";
    for (int i = 0; i < 40; i++) step(1'b0, 2'b00);
    seg = "R6 mid change";
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00);
    for (int i = 0; i < 50; i++) step(1'b0, 2'b10);
    seg = "R4 div3";
    for (int i = 0; i < 60; i++) step(1'b0, 2'b01);
    seg = "R4 code3";
    for (int i = 0; i < 60; i++) step(1'b0, 2'b11);
    seg = "R6 toggle";
    for (int i = 0; i < 120; i++) step(1'b0, (i % 5 == 0) ? 2'b00 : 2'b10);
    seg = "R6 per cycle";
    for (int i = 0; i < 100; i++) step(1'b0, 2'(i % 4));
    seg = "R2 mid reset";
    for (int i = 0; i < 2; i++) step(1'b1, 2'b10);
    seg = "R5 div4";
    for (int i = 0; i < 70; i++) step(1'b0, 2'b10);
    seg = "R2 late reset";
    step(1'b1, 2'b01);
    seg = "R5 div3";
    for (int i = 0; i < 50; i++) step(1'b0, 2'b01);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule